// File: doc/BRIEF.md
# Multi-Size Shift and Rotate Unit

This execution unit moves the bits of an 8-, 16- or 32-bit operand. It covers arithmetic shifts, logical shifts, plain rotates, rotates that pass through an extend bit, and a swap of the two 16-bit halves of a long operand. Alongside the shifted value it produces five condition flags: extend, negative, zero, overflow and carry. The flags follow the usual rules of an integer core.

The shift count comes from one of two places. It can be a 3-bit immediate that encodes one to eight places, or a 6-bit register value that may be anywhere from 0 to 63. Because the register count can be larger than the operand width, the unit must give the correct result when every bit is shifted out. A memory-operand mode forces a word-sized shift or rotate by exactly one place. Only the selected low bits of the operand move; the bits above them leave the unit unchanged.

The caller raises `start` for one cycle with all inputs valid. The result and the flags appear on registered outputs in the next cycle, together with a one-cycle `valid` pulse.

Top module: `shift_rotate_unit`

## Requirements
- R1: A `start` pulse makes `valid` high in the next cycle, with the result and the flags for that request. The result and the flags hold their values until the next `start`. After reset they are all zero.
- R2: The size code selects the operand width: 0 gives 8 bits, 1 gives 16 bits and 2 gives 32 bits. Result bits above the selected width equal the operand bits in those positions.
- R3: With `cnt_from_reg`=0 the count is `imm_cnt`, where the value 0 stands for 8. With `cnt_from_reg`=1 the count is `reg_cnt`, from 0 to 63.
- R4: Operation code 0 is an arithmetic shift and code 1 is a logical shift, with `dir_left`=1 meaning left. Left shifts fill with zeros. A logical right shift fills with zeros and an arithmetic right shift fills with copies of the sign bit. A count at or above the width gives all zeros, or all sign bits for an arithmetic right shift.
- R5: Operation code 2 rotates the sized operand with no extend bit. A rotate by 8 in either direction on a word exchanges its two bytes.
- R6: Operation code 3 rotates the sized operand and X together as a ring of width+1 bits.
- R7: For a nonzero count, C is the last bit moved out. X takes the same value as C for shifts and for rotates through X, and stays unchanged for plain rotates. For a zero count, C is 0 (or X for a rotate through X) and X is unchanged.
- R8: N is the most significant bit of the sized result and Z is set when the sized result is zero. V is set only by an arithmetic left shift whose top bit changes at some step of the shift; every other operation clears V.
- R9: With `mem_mode`=1 the unit shifts or rotates a 16-bit operand by exactly one place. The size and count inputs are ignored in this mode.
- R10: Operation code 4 exchanges the upper and lower 16-bit halves of the 32-bit operand and ignores the size, direction, count and mode inputs. It clears V and C, leaves X unchanged, and sets N and Z from the full 32-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| operand | input | 32 | Value to shift, rotate or swap |
| size | input | 2 | Width code: 0 = 8, 1 = 16, 2 = 32 bits |
| op | input | 3 | 0 arithmetic shift, 1 logical shift, 2 rotate, 3 rotate through X, 4 half swap |
| dir_left | input | 1 | 1 = left, 0 = right |
| cnt_from_reg | input | 1 | 1 = count from `reg_cnt`, 0 = count from `imm_cnt` |
| imm_cnt | input | 3 | Immediate count, 0 encodes 8 |
| reg_cnt | input | 6 | Register count, 0 to 63 |
| mem_mode | input | 1 | 1 = word operand shifted by one place |
| x_in | input | 1 | Current extend flag |
| result | output | 32 | Registered result |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| valid | output | 1 | Result valid, one cycle after `start` |

## Verification
The bench goes after register counts of 0, of exactly the width, and of more than 32. A unit that wrapped the count at the width would leave data behind where zeros or sign bits belong, and one that treated 0 as "no request" would fail to clear C or fail to copy X into C.

The bench checks that immediate 0 means eight places, and that a rotate through X by width+1 gives back the original value. A unit that built a width-bit ring instead of a width+1 ring would fail the second case.

Byte and word operations run with random data in the upper bits, which catches any unit that lets the upper bits leak. Overflow cases where the top bit changes and then changes back catch a unit that compares only the first and last values of the top bit.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2} size_e;
    typedef enum logic [2:0] {OP_ASH = 3'd0, OP_LSH = 3'd1, OP_ROT = 3'd2,
                              OP_ROTX = 3'd3, OP_SWAP = 3'd4} op_e;

    // Working state that passes through each one-place step
    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic              ext;
        logic              carry;
        logic              ovf;
    } ring_t;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic logic [IDX_W-1:0] top_index(size_e s, logic mem);
        if (mem)              return IDX_W'(15);
        else if (s == SZ_BYTE) return IDX_W'(7);
        else if (s == SZ_WORD) return IDX_W'(15);
        else                   return IDX_W'(DATA_W-1);
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(logic [IDX_W-1:0] top);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < DATA_W; b++) m[b] = (b <= int'(top));
        return m;
    endfunction

    // One place of movement; bits above 'top' are don't-care here
    function automatic ring_t one_step(ring_t r, op_e op, logic left, logic [IDX_W-1:0] top);
        ring_t  o;
        logic   out_bit;
        logic   fill;
        o = r;
        if (left) begin
            out_bit = r.val[top];
            case (op)
                OP_ROT:  fill = out_bit;
                OP_ROTX: fill = r.ext;
                default: fill = 1'b0;
            endcase
            o.val    = {r.val[DATA_W-2:0], fill};
        end else begin
            out_bit = r.val[0];
            case (op)
                OP_ASH:  fill = r.val[top];
                OP_ROT:  fill = out_bit;
                OP_ROTX: fill = r.ext;
                default: fill = 1'b0;
            endcase
            o.val      = {1'b0, r.val[DATA_W-1:1]};
            o.val[top] = fill;
        end
        o.carry = out_bit;
        if (op != OP_ROT) o.ext = out_bit;
        if (op == OP_ASH && left && (o.val[top] != r.val[top])) o.ovf = 1'b1;
        return o;
    endfunction
endpackage

// File: rtl/srx_count_sel.sv
module srx_count_sel
    import srx_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          from_reg,
    input  logic [2:0]    imm,
    input  logic [CW-1:0] regc,
    input  logic          mem,
    input  logic          swap,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] IMM_ZERO_MEANS = CW'(8);

    always_comb begin
        if (swap)          count = '0;
        else if (mem)      count = CW'(1);
        else if (from_reg) count = regc;
        else if (imm == 3'd0) count = IMM_ZERO_MEANS;
        else               count = CW'(imm);
    end
endmodule

// File: rtl/srx_shift_chain.sv
module srx_shift_chain
    import srx_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic              x_i,
    input  op_e               op_i,
    input  logic              left_i,
    input  logic [IDX_W-1:0]  top_i,
    input  logic [CW-1:0]     count_i,
    output ring_t             fin_o
);
    localparam int STEPS = (1 << CW) - 1;

    ring_t stage [STEPS+1];

    always_comb begin
        stage[0].val   = val_i;
        stage[0].ext   = x_i;
        stage[0].carry = (op_i == OP_ROTX) ? x_i : 1'b0;
        stage[0].ovf   = 1'b0;
    end

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        always_comb begin
            if (CW'(i) < count_i) stage[i+1] = one_step(stage[i], op_i, left_i, top_i);
            else                  stage[i+1] = stage[i];
        end
    end

    assign fin_o = stage[STEPS];
endmodule

// File: rtl/srx_flag_gen.sv
module srx_flag_gen
    import srx_pkg::*;
(
    input  logic [DATA_W-1:0] operand_i,
    input  ring_t             fin_i,
    input  logic [IDX_W-1:0]  top_i,
    input  op_e               op_i,
    input  logic              x_i,
    output logic [DATA_W-1:0] result_o,
    output flags_t            flags_o
);
    logic [DATA_W-1:0] mask;

    always_comb begin
        mask = width_mask(top_i);
        if (op_i == OP_SWAP) begin
            result_o  = {operand_i[HALF_W-1:0], operand_i[DATA_W-1:HALF_W]};
            flags_o.x = x_i;
            flags_o.n = result_o[DATA_W-1];
            flags_o.z = (result_o == '0);
            flags_o.v = 1'b0;
            flags_o.c = 1'b0;
        end else begin
            result_o  = (fin_i.val & mask) | (operand_i & ~mask);
            flags_o.x = fin_i.ext;
            flags_o.n = result_o[top_i];
            flags_o.z = ((result_o & mask) == '0);
            flags_o.v = fin_i.ovf;
            flags_o.c = fin_i.carry;
        end
    end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import srx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] operand,
    input  logic [1:0]  size,
    input  logic [2:0]  op,
    input  logic        dir_left,
    input  logic        cnt_from_reg,
    input  logic [2:0]  imm_cnt,
    input  logic [5:0]  reg_cnt,
    input  logic        mem_mode,
    input  logic        x_in,
    output logic [31:0] result,
    output logic        flag_x,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_v,
    output logic        flag_c,
    output logic        valid
);
    op_e               op_q;
    logic [IDX_W-1:0]  top;
    logic [CNT_W-1:0]  count;
    ring_t             fin;
    logic [DATA_W-1:0] res_c;
    flags_t            flg_c;

    assign op_q = op_e'(op);
    assign top  = top_index(size_e'(size), mem_mode);

    srx_count_sel #(.CW(CNT_W)) u_count (
        .from_reg (cnt_from_reg),
        .imm      (imm_cnt),
        .regc     (reg_cnt),
        .mem      (mem_mode),
        .swap     (op_q == OP_SWAP),
        .count    (count)
    );

    srx_shift_chain #(.CW(CNT_W)) u_chain (
        .val_i   (operand),
        .x_i     (x_in),
        .op_i    (op_q),
        .left_i  (dir_left),
        .top_i   (top),
        .count_i (count),
        .fin_o   (fin)
    );

    srx_flag_gen u_flags (
        .operand_i (operand),
        .fin_i     (fin),
        .top_i     (top),
        .op_i      (op_q),
        .x_i       (x_in),
        .result_o  (res_c),
        .flags_o   (flg_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            flag_x <= 1'b0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
            flag_c <= 1'b0;
            valid  <= 1'b0;
        end else begin
            valid <= start;
            if (start) begin
                result <= res_c;
                flag_x <= flg_c.x;
                flag_n <= flg_c.n;
                flag_z <= flg_c.z;
                flag_v <= flg_c.v;
                flag_c <= flg_c.c;
            end
        end
    end

    // R1: response one cycle after the strobe, held otherwise
    p_valid_after_start_r1: assert property (@(posedge clk) disable iff (rst)
        start |=> valid);
    p_hold_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(result) && $stable(flag_c) && $stable(flag_x));
    // R2: byte operations keep the upper 24 bits
    p_upper_kept_r2: assert property (@(posedge clk) disable iff (rst)
        start && !mem_mode && op != 3'd4 && size == 2'd0
        |=> result[31:8] == $past(operand[31:8]));
    // R9: memory mode keeps the upper half
    p_mem_upper_kept_r9: assert property (@(posedge clk) disable iff (rst)
        start && mem_mode && op != 3'd4 |=> result[31:16] == $past(operand[31:16]));
    // R10: halves exchanged
    p_swap_halves_r10: assert property (@(posedge clk) disable iff (rst)
        start && op == 3'd4
        |=> result == {$past(operand[15:0]), $past(operand[31:16])} && !flag_c && !flag_v);
    // R8: overflow only from arithmetic left shift
    p_v_only_asl_r8: assert property (@(posedge clk) disable iff (rst)
        start && !(op == 3'd0 && dir_left) |=> !flag_v);
    p_nz_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        valid |-> !(flag_n && flag_z));
    // R7: zero count leaves X alone
    p_zero_count_x_r7: assert property (@(posedge clk) disable iff (rst)
        start && cnt_from_reg && reg_cnt == 6'd0 && !mem_mode
        |=> flag_x == $past(x_in) && !flag_v);
endmodule

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  size = '0;
    logic [2:0]  op = '0;
    logic        dir_left = 1'b0;
    logic        cnt_from_reg = 1'b0;
    logic [2:0]  imm_cnt = '0;
    logic [5:0]  reg_cnt = '0;
    logic        mem_mode = 1'b0;
    logic        x_in = 1'b0;
    logic [31:0] result;
    logic        flag_x, flag_n, flag_z, flag_v, flag_c, valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shift_rotate_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .operand(operand), .size(size),
        .op(op), .dir_left(dir_left), .cnt_from_reg(cnt_from_reg),
        .imm_cnt(imm_cnt), .reg_cnt(reg_cnt), .mem_mode(mem_mode), .x_in(x_in),
        .result(result), .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .valid(valid)
    );

    // Expected {result, x, n, z, v, c} from the requirements
    function automatic logic [36:0] model(logic [31:0] a, logic [1:0] sz, logic [2:0] o,
                                          logic lf, logic fr, logic [2:0] im,
                                          logic [5:0] rc, logic mm, logic xi);
        int w, n;
        logic [31:0] d, msk, r;
        logic x, c, v, b, m0;
        if (o == 3'd4) begin
            r = {a[15:0], a[31:16]};
            return {r, xi, r[31], r == 0, 1'b0, 1'b0};
        end
        w = mm ? 16 : (sz == 0 ? 8 : (sz == 1 ? 16 : 32));
        n = mm ? 1 : (fr ? int'(rc) : (im == 0 ? 8 : int'(im)));
        msk = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
        d = a & msk;
        x = xi; v = 1'b0;
        c = (o == 3'd3) ? xi : 1'b0;
        for (int k = 0; k < n; k++) begin
            m0 = d[w-1];
            if (lf) begin
                b = d[w-1];
                d = (d << 1) & msk;
                if (o == 3'd2) d[0] = b;
                if (o == 3'd3) d[0] = x;
            end else begin
                b = d[0];
                d = d >> 1;
                if (o == 3'd0) d[w-1] = m0;
                if (o == 3'd2) d[w-1] = b;
                if (o == 3'd3) d[w-1] = x;
            end
            c = b;
            if (o != 3'd2) x = b;
            if (o == 3'd0 && lf && d[w-1] != m0) v = 1'b1;
        end
        r = d | (a & ~msk);
        return {r, x, d[w-1], d == 0, v, c};
    endfunction

    task automatic run(string tag, logic [31:0] a, logic [1:0] sz, logic [2:0] o,
                       logic lf, logic fr, logic [2:0] im, logic [5:0] rc,
                       logic mm, logic xi);
        logic [36:0] exp, got;
        @(negedge clk);
        operand = a; size = sz; op = o; dir_left = lf; cnt_from_reg = fr;
        imm_cnt = im; reg_cnt = rc; mem_mode = mm; x_in = xi; start = 1'b1;
        exp = model(a, sz, o, lf, fr, im, rc, mm, xi);
        @(negedge clk);
        start = 1'b0;
        got = {result, flag_x, flag_n, flag_z, flag_v, flag_c};
        checks++;
        if (got !== exp || valid !== 1'b1) begin
            fails++;
            $display("FAIL %s: got %h valid %b, expected %h valid 1", tag, got, valid, exp);
        end
    endtask

    task automatic expect_bit(string tag, logic actual, logic want);
        checks++;
        if (actual !== want) begin
            fails++;
            $display("FAIL %s: got %b, expected %b", tag, actual, want);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        string tg;
        logic [2:0] ro;
        logic mm;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        checks++;
        if ({result, flag_x, flag_n, flag_z, flag_v, flag_c, valid} !== '0) begin
            fails++;
            $display("FAIL R1 reset: got %h, expected 0", result);
        end
        // R5: word rotate by 8 is a byte exchange
        run("R5 rol8", 32'hAAAA_1234, 2'd1, 3'd2, 1'b1, 1'b0, 3'd0, 6'd0, 1'b0, 1'b0);
        checks++;
        if (result !== 32'hAAAA_3412) begin
            fails++;
            $display("FAIL R5: got %h, expected aaaa3412", result);
        end
        run("R5 ror8", 32'h0000_BEEF, 2'd1, 3'd2, 1'b0, 1'b1, 3'd0, 6'd8, 1'b0, 1'b1);
        // R1 hold after the response
        held = result;
        @(negedge clk);
        expect_bit("R1 valid drop", valid, 1'b0);
        checks++;
        if (result !== held) begin
            fails++;
            $display("FAIL R1 hold: got %h, expected %h", result, held);
        end
        // R3 immediate zero means eight
        run("R3 imm0", 32'h0000_00FF, 2'd2, 3'd1, 1'b1, 1'b0, 3'd0, 6'd63, 1'b0, 1'b0);
        checks++;
        if (result !== 32'h0000_FF00) begin
            fails++;
            $display("FAIL R3: got %h, expected 0000ff00", result);
        end
        // R4 oversize counts
        run("R4 lsr40", 32'hFFFF_FFFF, 2'd2, 3'd1, 1'b0, 1'b1, 3'd0, 6'd40, 1'b0, 1'b1);
        run("R4 asr20 byte", 32'h1234_5680, 2'd0, 3'd0, 1'b0, 1'b1, 3'd0, 6'd20, 1'b0, 1'b0);
        run("R4 lsl32", 32'h8000_0001, 2'd2, 3'd1, 1'b1, 1'b1, 3'd0, 6'd32, 1'b0, 1'b0);
        // R6 ring of width+1 returns to start
        run("R6 roxl9", 32'h5500_00A5, 2'd0, 3'd3, 1'b1, 1'b1, 3'd0, 6'd9, 1'b0, 1'b1);
        run("R6 roxr1", 32'h0000_0001, 2'd0, 3'd3, 1'b0, 1'b0, 3'd1, 6'd0, 1'b0, 1'b0);
        // R7 zero count
        run("R7 zero rotx", 32'h0000_0010, 2'd1, 3'd3, 1'b1, 1'b1, 3'd0, 6'd0, 1'b0, 1'b1);
        expect_bit("R7 zero rotx C", flag_c, 1'b1);
        run("R7 zero lsl", 32'h0000_0010, 2'd1, 3'd1, 1'b1, 1'b1, 3'd0, 6'd0, 1'b0, 1'b1);
        expect_bit("R7 zero lsl C", flag_c, 1'b0);
        run("R7 rot keeps X", 32'h0000_0080, 2'd0, 3'd2, 1'b1, 1'b0, 3'd1, 6'd0, 1'b0, 1'b0);
        expect_bit("R7 rot X", flag_x, 1'b0);
        // R8 overflow: top bit changes then changes back
        run("R8 asl v", 32'h0000_0040, 2'd0, 3'd0, 1'b1, 1'b0, 3'd2, 6'd0, 1'b0, 1'b0);
        expect_bit("R8 V", flag_v, 1'b1);
        run("R8 asl nov", 32'h0000_00C0, 2'd0, 3'd0, 1'b1, 1'b0, 3'd1, 6'd0, 1'b0, 1'b0);
        expect_bit("R8 no V", flag_v, 1'b0);
        // R9 memory mode ignores size and counts
        run("R9 mem", 32'hDEAD_8001, 2'd0, 3'd2, 1'b1, 1'b1, 3'd5, 6'd17, 1'b1, 1'b0);
        checks++;
        if (result !== 32'hDEAD_0003) begin
            fails++;
            $display("FAIL R9: got %h, expected dead0003", result);
        end
        // R10 swap
        run("R10 swap", 32'h8001_0000, 2'd0, 3'd4, 1'b1, 1'b1, 3'd3, 6'd9, 1'b1, 1'b1);
        // R2 and random mix
        void'($urandom(32'h1F2E_3D4C));
        for (int i = 0; i < 3000; i++) begin
            ro = 3'($urandom % 5);
            mm = ($urandom % 8) == 0;
            tg = (ro == 3'd4) ? "R10 rand" : mm ? "R9 rand" :
                 (ro == 3'd2) ? "R5 rand" : (ro == 3'd3) ? "R6 rand" : "R4 R2 rand";
            run(tg, $urandom, 2'($urandom % 3), ro, 1'($urandom), 1'($urandom),
                3'($urandom), 6'($urandom), mm, 1'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule